// File: doc/BRIEF.md
# Duty-Cycled Overcharge Detection Sequencer

This block decides when a two-cell series battery pack must stop accepting charge. A timing generator splits time into a short operating window followed by a waiting window ten times as long. The comparator strobe is high only during the operating window, so the analog comparators draw current only then. On the last cycle of each operating window the block takes one sample: the OR of the two per-cell over-threshold flags. The flags arrive already synchronized.

A run of consecutive positive samples confirms an overcharge and sets a latch. The latch starts a delay counter, and when the delay runs out the charge-inhibit output goes high. A discharge flag seen while the latch is set and the delay is still running restarts the delay. Sampling carries on at the same rate while the block is in overcharge. The first negative sample acts as the reset path: it clears the run counter, the latch, the delay counter and charge-inhibit. While samples stay positive, no reset can happen.

The window lengths, the confirmation count and the delay are parameters counted in clock cycles.

Top module: `ovc_guard_seq`

## Requirements
- R1: In reset and in the first cycle after reset, `cmp_enable` is 1 (an operating window begins) and `chg_inhibit` is 0. The run counter, the latch and the delay counter are cleared.
- R2: `cmp_enable` repeats a pattern of `OP_TICKS` cycles high followed by `WAIT_TICKS` cycles low. The default sets `WAIT_TICKS` to ten times `OP_TICKS`.
- R3: One sample is taken on the clock edge that ends the last cycle of each operating window. Its value is `cell_hi_over | cell_lo_over`, so either cell alone makes the sample positive.
- R4: The latch sets on the sample edge that completes `CONFIRM_RUN` consecutive positive samples (default 3, so more than two are needed). Flag values outside the sample cycle have no effect.
- R5: With `discharge_det` low, `chg_inhibit` rises exactly `DELAY_TICKS` cycles after the latch sets.
- R6: While the latch is set and `chg_inhibit` is still low, a cycle with `discharge_det` high restarts the delay. `chg_inhibit` then rises `DELAY_TICKS` cycles after the last such cycle.
- R7: Once `chg_inhibit` is high, it stays high while every sample is positive, whatever `discharge_det` does.
- R8: A negative sample clears the run counter, the latch, the delay counter and `chg_inhibit`, all on the sample edge itself. A later detection then needs a complete new run of positive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_hi_over | input | 1 | Upper cell above the overcharge threshold |
| cell_lo_over | input | 1 | Lower cell above the overcharge threshold |
| discharge_det | input | 1 | Discharge current detected |
| cmp_enable | output | 1 | Comparator power strobe, high during the operating window |
| chg_inhibit | output | 1 | Blocks charging when high |

## Verification
The hardest case to reach from the ports is a discharge restart that moves the inhibit edge without ever letting it happen early. The delay has to be running, so the latch must be set, and the flags must stay positive at every sample so the reset path cannot interfere. The stimulus holds one cell flag high across whole window periods until the latch sets. It then pulses `discharge_det` at intervals shorter than the delay, so the timer is restarted before it can expire. Noise rejection is exercised the same way. Flags are driven high only while the strobe is low, and positive runs are broken by single negative periods. Throughout, a behavioural model compares both outputs on every cycle.

// File: rtl/ovg_pkg.sv
package ovg_pkg;

  // Phase of the duty-cycle generator.
  typedef enum logic {
    PH_WAIT = 1'b0,
    PH_OPER = 1'b1
  } phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ovg_phase_gen.sv
module ovg_phase_gen
  import ovg_pkg::*;
#(
  parameter int OP_TICKS   = 4,
  parameter int WAIT_TICKS = 40
) (
  input  logic clk,
  input  logic rst,
  output logic cmp_en,
  output logic sample_stb
);
  localparam int LONGEST = max2(OP_TICKS, WAIT_TICKS);
  localparam int CW      = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] OP_LAST   = CW'(OP_TICKS - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_TICKS - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (phase_q == PH_OPER) ? (cnt_q == OP_LAST) : (cnt_q == WAIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_OPER;
      cnt_q   <= '0;
    end else if (at_end) begin
      cnt_q   <= '0;
      phase_q <= (phase_q == PH_OPER) ? PH_WAIT : PH_OPER;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cmp_en     = (phase_q == PH_OPER);
  assign sample_stb = (phase_q == PH_OPER) && (cnt_q == OP_LAST);

  // The strobe only falls right after the sampling cycle.
  assert_strobe_falls_after_sample_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cmp_en) |-> $past(sample_stb));

  // The counter never runs past the longer window.
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LONGEST - 1));

endmodule

// File: rtl/ovg_confirm.sv
module ovg_confirm #(
  parameter int CONFIRM_RUN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_stb,
  input  logic cell_hi_over,
  input  logic cell_lo_over,
  output logic latched,
  output logic clr
);
  localparam int RW = $clog2(CONFIRM_RUN + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(CONFIRM_RUN - 1);

  logic [RW-1:0] run_q;
  logic          lat_q;
  logic          pos;

  assign pos = cell_hi_over | cell_lo_over;
  assign clr = sample_stb & ~pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lat_q <= 1'b0;
    end else if (sample_stb) begin
      if (!pos) begin
        run_q <= '0;
        lat_q <= 1'b0;
      end else if (!lat_q) begin
        if (run_q == RUN_LAST) lat_q <= 1'b1;
        else                   run_q <= run_q + 1'b1;
      end
    end
  end

  assign latched = lat_q;

  // The run counter never passes the confirmation count.
  assert_run_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_LAST);

endmodule

// File: rtl/ovg_delay_timer.sv
module ovg_delay_timer #(
  parameter int DELAY_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic armed,
  input  logic discharge,
  output logic inhibit
);
  localparam int TW = $clog2(DELAY_TICKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(DELAY_TICKS - 1);

  logic [TW-1:0] t_q;
  logic          inh_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      t_q   <= '0;
      inh_q <= 1'b0;
    end else if (armed && !inh_q) begin
      if (discharge)         t_q   <= '0;
      else if (t_q == T_LAST) inh_q <= 1'b1;
      else                   t_q   <= t_q + 1'b1;
    end
  end

  assign inhibit = inh_q;

  assert_timer_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    t_q <= T_LAST);

endmodule

// File: rtl/ovc_guard_seq.sv
module ovc_guard_seq #(
  parameter int OP_TICKS    = 4,
  parameter int WAIT_TICKS  = 10 * OP_TICKS,
  parameter int CONFIRM_RUN = 3,
  parameter int DELAY_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic cell_hi_over,
  input  logic cell_lo_over,
  input  logic discharge_det,
  output logic cmp_enable,
  output logic chg_inhibit
);
  logic sample_stb;
  logic latched;
  logic clr;

  ovg_phase_gen #(
    .OP_TICKS  (OP_TICKS),
    .WAIT_TICKS(WAIT_TICKS)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .cmp_en    (cmp_enable),
    .sample_stb(sample_stb)
  );

  ovg_confirm #(
    .CONFIRM_RUN(CONFIRM_RUN)
  ) u_confirm (
    .clk         (clk),
    .rst         (rst),
    .sample_stb  (sample_stb),
    .cell_hi_over(cell_hi_over),
    .cell_lo_over(cell_lo_over),
    .latched     (latched),
    .clr         (clr)
  );

  ovg_delay_timer #(
    .DELAY_TICKS(DELAY_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .armed    (latched),
    .discharge(discharge_det),
    .inhibit  (chg_inhibit)
  );

  // Inhibit is only ever seen together with a set latch.
  assert_inhibit_needs_latch_R5: assert property (@(posedge clk) disable iff (rst)
    chg_inhibit |-> latched);

  // The latch only rises right after a sampling cycle.
  assert_latch_on_sample_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(latched) |-> $past(sample_stb));

  // A discharge while the delay is running keeps inhibit low next cycle.
  assert_discharge_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (latched && !chg_inhibit && discharge_det && !clr) |=> !chg_inhibit);

  // A positive sample cannot drop an asserted inhibit.
  assert_reset_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (chg_inhibit && sample_stb && (cell_hi_over || cell_lo_over)) |=> chg_inhibit);

  // A negative sample clears latch and inhibit.
  assert_clear_on_negative_R8: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && !cell_hi_over && !cell_lo_over) |=> (!chg_inhibit && !latched));

endmodule

// File: tb/ovc_guard_seq_tb_top.sv
`timescale 1ns/1ps
module ovc_guard_seq_tb_top;
  localparam int OP     = 2;
  localparam int WT     = 20;
  localparam int CONF   = 3;
  localparam int DLY    = 50;
  localparam int PERIOD = OP + WT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi = 1'b0, lo = 1'b0, dis = 1'b0;
  logic cmp_enable, chg_inhibit;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ovc_guard_seq #(
    .OP_TICKS(OP), .WAIT_TICKS(WT), .CONFIRM_RUN(CONF), .DELAY_TICKS(DLY)
  ) dut_i (
    .clk(clk), .rst(rst), .cell_hi_over(hi), .cell_lo_over(lo),
    .discharge_det(dis), .cmp_enable(cmp_enable), .chg_inhibit(chg_inhibit)
  );

  // Behavioural reference model
  bit m_op;
  int m_cnt, m_run, m_tc;
  bit m_lat, m_inh;

  always @(posedge clk) begin
    bit samp, pos, clr;
    if (rst) begin
      m_op = 1; m_cnt = 0; m_run = 0; m_lat = 0; m_tc = 0; m_inh = 0;
    end else begin
      samp = m_op && (m_cnt == OP - 1);
      pos  = hi || lo;
      clr  = samp && !pos;
      if (clr) begin
        m_tc = 0; m_inh = 0;
      end else if (m_lat && !m_inh) begin
        if (dis) m_tc = 0;
        else if (m_tc == DLY - 1) m_inh = 1;
        else m_tc++;
      end
      if (samp) begin
        if (!pos) begin
          m_run = 0; m_lat = 0;
        end else if (!m_lat) begin
          if (m_run == CONF - 1) m_lat = 1;
          else m_run++;
        end
      end
      if (m_cnt == (m_op ? OP : WT) - 1) begin
        m_cnt = 0; m_op = !m_op;
      end else m_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(cmp_enable == m_op, "R2", "cmp_enable vs model", cmp_enable, m_op);
      check(chg_inhibit == m_inh, cur_req, "chg_inhibit vs model", chg_inhibit, m_inh);
    end
  end

  task automatic periods(input int n);
    repeat (n * PERIOD) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    check(cmp_enable == 1'b1, "R1", "cmp_enable in reset", cmp_enable, 1);
    check(chg_inhibit == 1'b0, "R1", "chg_inhibit in reset", chg_inhibit, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmp_enable == 1'b1, "R1", "cmp_enable after reset", cmp_enable, 1);
    check(chg_inhibit == 1'b0, "R1", "chg_inhibit after reset", chg_inhibit, 0);

    // R2 duty cycle
    cur_req = "R2";
    ones = 0;
    for (int i = 0; i < 10 * PERIOD; i++) begin
      @(negedge clk);
      if (cmp_enable) ones++;
    end
    check(ones == 10 * OP, "R2", "strobe-high cycles in 10 periods", ones, 10 * OP);

    // R4 two positives only, then negative
    cur_req = "R4";
    hi = 1; periods(2);
    hi = 0; periods(1);
    repeat (DLY + 30) @(negedge clk);
    check(chg_inhibit == 1'b0, "R4", "two positive samples do not latch", chg_inhibit, 0);

    // R4 flags high only while strobe low
    for (int i = 0; i < 6 * PERIOD; i++) begin
      hi = !m_op;
      @(negedge clk);
    end
    hi = 0;
    repeat (DLY + 10) @(negedge clk);
    check(chg_inhibit == 1'b0, "R4", "flags outside sample cycle ignored", chg_inhibit, 0);

    // R8 broken run: pos,pos,neg,pos,pos,neg
    cur_req = "R8";
    lo = 1; periods(2);
    lo = 0; periods(1);
    lo = 1; periods(2);
    lo = 0; periods(1);
    repeat (DLY + 10) @(negedge clk);
    check(chg_inhibit == 1'b0, "R8", "negative sample restarts run", chg_inhibit, 0);

    // R3 lower cell alone, R5 delay, R7 hold
    cur_req = "R5";
    lo = 1; periods(3);
    repeat (DLY + 5) @(negedge clk);
    check(chg_inhibit == 1'b1, "R3", "lower cell alone confirms overcharge", chg_inhibit, 1);
    cur_req = "R7";
    periods(3);
    check(chg_inhibit == 1'b1, "R7", "inhibit held while positive", chg_inhibit, 1);
    dis = 1; repeat (5) @(negedge clk); dis = 0;
    check(chg_inhibit == 1'b1, "R7", "discharge does not clear inhibit", chg_inhibit, 1);
    cur_req = "R8";
    lo = 0; periods(1);
    check(chg_inhibit == 1'b0, "R8", "inhibit cleared by negative sample", chg_inhibit, 0);

    // R6 discharge restarts the delay
    cur_req = "R6";
    hi = 1; periods(3);
    for (int k = 0; k < 4; k++) begin
      repeat (20) @(negedge clk);
      dis = 1; @(negedge clk); dis = 0;
    end
    check(chg_inhibit == 1'b0, "R6", "discharge postpones inhibit", chg_inhibit, 0);
    cur_req = "R5";
    repeat (DLY + 10) @(negedge clk);
    check(chg_inhibit == 1'b1, "R5", "inhibit after undisturbed delay", chg_inhibit, 1);
    cur_req = "R8";
    hi = 0; periods(1);
    check(chg_inhibit == 1'b0, "R8", "final clear", chg_inhibit, 0);

    finish_run();
  end
endmodule